// File: doc/BRIEF.md
# Branch Trace Buffer

This block keeps a short history of where program flow jumped. Each cycle in which the core raises its taken-branch strobe, the block can store one record. A record holds the address of the jump instruction (source) and the address it went to (target). Records go into a ring of slots. When the ring is full, each new record replaces the oldest one and sets a sticky overflow flag.

Software controls and drains the buffer through a small register bus with three word registers. The control register gates power and recording, and holds the overflow flag and a loop-compression bit. The status register gives the number of complete records held. The data register pops one address per read. Records come out newest first, target before source. The count drops only once the source half has been read.

Recording can be paused with the contents kept. Dropping power empties the buffer.

Top module: `btrace_buf`

## Requirements
- R1: After a synchronous reset, the control register reads 0, the status register reads 0 and a data read returns 0.
- R2: A record is stored only in a cycle where br_valid is high and both control bit 0 (power) and control bit 1 (record enable) are set. Writing 0x1 stops recording and keeps the stored records. Writing 0x2 (enable without power) stores nothing.
- R3: The status register (offset 1) reads the number of complete records held, from 0 up to DEPTH. Each stored record raises it by one until it reaches DEPTH.
- R4: Data reads (offset 2) return records in last-in, first-out order.
- R5: Within a record, the first data read returns the target address and the second returns the source address. The count drops by one only after the source read. Between the two reads the status still shows the earlier count.
- R6: A data read while the count is zero, with no record stored in the same cycle, returns 0 and changes no state.
- R7: A record stored while the count equals DEPTH overwrites the oldest record, leaves the count at DEPTH and sets control bit 2 (overflow). Writing the control register with bit 2 set and bit 0 set clears the flag.
- R8: While control bit 0 is clear, the buffer is emptied: the count returns to 0, any half-read record is dropped and the overflow flag clears.
- R9: When a record is stored and the data register is read in the same cycle, the store happens first and the read returns the target of the new record. A store always restarts the half-read state, so the next read of an older record begins again with its target.
- R10: Register reads return data on reg_rdata one cycle after reg_rd. Offset 0 reads {bit3 loop-compress, bit2 overflow, bit1 enable, bit0 power}. The loop-compress bit is written and read back as stored. Offset 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Taken-branch strobe, one record per cycle |
| br_src | input | ADDR_W | Address of the jump instruction |
| br_dst | input | ADDR_W | Address the jump lands on |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register word offset |
| reg_wdata | input | 4 | Write data (only the control register is writable) |
| reg_rdata | output | ADDR_W | Registered read data |

## Verification
The bench builds the block with DEPTH set to 4 and 32-bit addresses. The shallow ring lets a handful of branches reach the full state, wrap the write pointer and set the overflow flag. It can then drain the ring across the wrap point in a few hundred cycles. The same short ring also makes it cheap to mix a same-cycle store and pop with a pending half-read record. It also lets the bench drop power on a full, overflowed buffer and check that everything clears.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // register word offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_DATA = 2;
  // control bit positions
  localparam int CB_PWR = 0;
  localparam int CB_EN  = 1;
  localparam int CB_OVF = 2;
  localparam int CB_LC  = 3;
  localparam int CTRL_W = 4;

  typedef struct packed {
    logic lc;
    logic ovf;
    logic en;
    logic pwr;
  } ctrl_t;
endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              ovf_evt,
  output ctrl_t             ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else begin
      if (wr_en) begin
        ctrl.pwr <= wdata[CB_PWR];
        ctrl.en  <= wdata[CB_EN];
        ctrl.lc  <= wdata[CB_LC];
      end
      // power-down clears the flag; a new overflow beats a W1C clear
      if (wr_en && !wdata[CB_PWR])
        ctrl.ovf <= 1'b0;
      else if (ovf_evt)
        ctrl.ovf <= 1'b1;
      else if (wr_en && wdata[CB_OVF])
        ctrl.ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr,
  input  logic              rec,
  input  logic [ADDR_W-1:0] br_src,
  input  logic [ADDR_W-1:0] br_dst,
  input  logic              pop_req,
  output logic              pop_en,
  output logic [ADDR_W-1:0] pop_val,
  output logic [CW-1:0]     cnt,
  output logic              half,
  output logic              ovf_evt
);
  logic [ADDR_W-1:0] mem_src [DEPTH];
  logic [ADDR_W-1:0] mem_dst [DEPTH];
  logic [PW-1:0] head, head_inc, head_a, newest, head_n;
  logic [CW-1:0] cnt_a, cnt_n;
  logic          half_a, half_n, full;

  // storage: no reset, single write port, so it maps onto small RAM
  always_ff @(posedge clk) begin
    if (rec) begin
      mem_src[head] <= br_src;
      mem_dst[head] <= br_dst;
    end
  end

  always_comb begin
    full     = (cnt == CW'(DEPTH));
    head_inc = (head == PW'(DEPTH - 1)) ? '0 : head + PW'(1);
    // step 1: the store
    head_a   = rec ? head_inc : head;
    cnt_a    = (rec && !full) ? cnt + CW'(1) : cnt;
    half_a   = rec ? 1'b0 : half;
    newest   = (head_a == '0) ? PW'(DEPTH - 1) : head_a - PW'(1);
    // step 2: the pop of the newest record
    pop_en   = pop_req && (cnt_a != '0);
    if (rec)
      pop_val = br_dst;
    else
      pop_val = half ? mem_src[newest] : mem_dst[newest];
    head_n = head_a;
    cnt_n  = cnt_a;
    half_n = half_a;
    if (pop_en) begin
      if (half_a) begin
        half_n = 1'b0;
        head_n = newest;
        cnt_n  = cnt_a - CW'(1);
      end else begin
        half_n = 1'b1;
      end
    end
    ovf_evt = rec && full;
  end

  always_ff @(posedge clk) begin
    if (rst || !pwr) begin
      head <= '0;
      cnt  <= '0;
      half <= 1'b0;
    end else begin
      head <= head_n;
      cnt  <= cnt_n;
      half <= half_n;
    end
  end
endmodule

// File: rtl/btb_readout.sv
module btb_readout
  import btb_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CW     = 5,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [REG_AW-1:0] addr,
  input  ctrl_t             ctrl,
  input  logic [CW-1:0]     cnt,
  input  logic              pop_en,
  input  logic [DW-1:0]     pop_val,
  output logic [DW-1:0]     rdata
);
  logic [CTRL_W-1:0] cbits;
  assign cbits = ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (addr == REG_AW'(OFS_CTRL))
        rdata <= DW'(cbits);
      else if (addr == REG_AW'(OFS_STAT))
        rdata <= DW'(cnt);
      else if (addr == REG_AW'(OFS_DATA))
        rdata <= pop_en ? pop_val : '0;
      else
        rdata <= '0;
    end
  end
endmodule

// File: rtl/btrace_buf.sv
module btrace_buf
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  parameter int REG_AW = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_src,
  input  logic [ADDR_W-1:0] br_dst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata
);
  ctrl_t             ctrl;
  logic              ctrl_wr, data_rd, rec;
  logic              pop_en, ovf_evt, half;
  logic [ADDR_W-1:0] pop_val;
  logic [CW-1:0]     cnt;

  assign ctrl_wr = reg_wr && (reg_addr == REG_AW'(OFS_CTRL));
  assign data_rd = reg_rd && (reg_addr == REG_AW'(OFS_DATA));
  assign rec     = br_valid && ctrl.pwr && ctrl.en;

  btb_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (ctrl_wr),
    .wdata  (reg_wdata),
    .ovf_evt(ovf_evt),
    .ctrl   (ctrl)
  );

  btb_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst    (rst),
    .pwr    (ctrl.pwr),
    .rec    (rec),
    .br_src (br_src),
    .br_dst (br_dst),
    .pop_req(data_rd),
    .pop_en (pop_en),
    .pop_val(pop_val),
    .cnt    (cnt),
    .half   (half),
    .ovf_evt(ovf_evt)
  );

  btb_readout #(.DW(ADDR_W), .CW(CW), .REG_AW(REG_AW)) u_read (
    .clk    (clk),
    .rst    (rst),
    .rd     (reg_rd),
    .addr   (reg_addr),
    .ctrl   (ctrl),
    .cnt    (cnt),
    .pop_en (pop_en),
    .pop_val(pop_val),
    .rdata  (reg_rdata)
  );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  parameter int REG_AW = 2,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              br_valid,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [ADDR_W-1:0] reg_rdata,
  input logic              pwr,
  input logic              en,
  input logic              ovf,
  input logic [CW-1:0]     cnt,
  input logic              half
);
  a_r2_no_rec_off: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !(pwr && en) && !reg_rd) |=> (cnt <= $past(cnt)));

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  a_r3_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (br_valid && pwr && en && !reg_rd && !reg_wr && cnt < CW'(DEPTH))
      |=> (cnt == $past(cnt) + CW'(1)));

  a_r5_half_nonempty: assert property (@(posedge clk) disable iff (rst)
    half |-> (cnt != '0));

  a_r6_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == REG_AW'(2) && cnt == '0 && !(br_valid && pwr && en))
      |=> (reg_rdata == '0 && cnt == '0));

  a_r7_ovf_set: assert property (@(posedge clk) disable iff (rst)
    (br_valid && pwr && en && !reg_wr && cnt == CW'(DEPTH)) |=> ovf);

  a_r8_off_empty: assert property (@(posedge clk) disable iff (rst)
    !pwr |=> (cnt == '0 && !half));
endmodule

bind btrace_buf btb_checker #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .REG_AW(REG_AW), .CW(CW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .br_valid (br_valid),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .pwr      (ctrl.pwr),
  .en       (ctrl.en),
  .ovf      (ctrl.ovf),
  .cnt      (cnt),
  .half     (half)
);

// File: tb/sim_btrace_buf.sv
module sim_btrace_buf;
  localparam int AW = 32;
  localparam int DP = 4;
  localparam int RA = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          br_valid = 1'b0;
  logic [AW-1:0] br_src = '0;
  logic [AW-1:0] br_dst = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [RA-1:0] reg_addr = '0;
  logic [3:0]    reg_wdata = '0;
  logic [AW-1:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;

  btrace_buf #(.ADDR_W(AW), .DEPTH(DP), .REG_AW(RA)) u0 (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [RA-1:0] a, input logic [3:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [RA-1:0] a, input logic [AW-1:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(tag, reg_rdata, exp);
  endtask

  task automatic push(input logic [AW-1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    br_valid = 1'b1; br_src = s; br_dst = d;
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic push_rd_chk(input string tag, input logic [AW-1:0] s,
                             input logic [AW-1:0] d, input logic [AW-1:0] exp);
    @(negedge clk);
    br_valid = 1'b1; br_src = s; br_dst = d;
    reg_rd = 1'b1; reg_addr = 2'd2;
    @(negedge clk);
    br_valid = 1'b0; reg_rd = 1'b0;
    check(tag, reg_rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl after reset", 2'd0, 32'h0);
    rd_chk("R1 status after reset", 2'd1, 32'h0);
    rd_chk("R1 data after reset", 2'd2, 32'h0);
  endtask

  task automatic t_basic;
    wr(2'd0, 4'h3);
    push(32'h0224, 32'h0250);
    push(32'h025a, 32'h0234);
    push(32'h023c, 32'h026c);
    wr(2'd0, 4'h1);
    rd_chk("R3 status three", 2'd1, 32'd3);
    push(32'h0abc, 32'h0def);
    rd_chk("R2 paused keeps count", 2'd1, 32'd3);
    rd_chk("R10 ctrl reads 1", 2'd0, 32'h1);
    rd_chk("R5 newest target", 2'd2, 32'h026c);
    rd_chk("R5 status held mid-record", 2'd1, 32'd3);
    rd_chk("R5 newest source", 2'd2, 32'h023c);
    rd_chk("R5 status after source", 2'd1, 32'd2);
    rd_chk("R4 second target", 2'd2, 32'h0234);
    rd_chk("R4 second source", 2'd2, 32'h025a);
    rd_chk("R4 oldest target", 2'd2, 32'h0250);
    rd_chk("R4 oldest source", 2'd2, 32'h0224);
    rd_chk("R3 status drained", 2'd1, 32'd0);
    rd_chk("R6 empty read", 2'd2, 32'h0);
    rd_chk("R6 status after empty read", 2'd1, 32'd0);
  endtask

  task automatic t_overflow;
    wr(2'd0, 4'h3);
    for (int i = 1; i <= 6; i++) push(32'h1000 + i * 16, 32'h2000 + i * 16);
    rd_chk("R7 count stays at depth", 2'd1, DP);
    rd_chk("R7 overflow flag set", 2'd0, 32'h7);
    wr(2'd0, 4'h7);
    rd_chk("R7 overflow cleared", 2'd0, 32'h3);
    for (int i = 6; i >= 3; i--) begin
      rd_chk("R7 surviving target", 2'd2, 32'h2000 + i * 16);
      rd_chk("R7 surviving source", 2'd2, 32'h1000 + i * 16);
    end
    rd_chk("R7 drained after wrap", 2'd1, 32'd0);
  endtask

  task automatic t_simul;
    push_rd_chk("R9 push+read on empty", 32'h3a00, 32'h3b00, 32'h3b00);
    rd_chk("R9 status after same-cycle", 2'd1, 32'd1);
    rd_chk("R9 source after same-cycle", 2'd2, 32'h3a00);
    rd_chk("R9 status empty", 2'd1, 32'd0);
    push(32'h4a00, 32'h4b00);
    rd_chk("R9 A target", 2'd2, 32'h4b00);
    push_rd_chk("R9 B target first", 32'h5a00, 32'h5b00, 32'h5b00);
    rd_chk("R9 status two", 2'd1, 32'd2);
    rd_chk("R9 B source", 2'd2, 32'h5a00);
    rd_chk("R9 A target again", 2'd2, 32'h4b00);
    rd_chk("R9 A source", 2'd2, 32'h4a00);
    rd_chk("R9 status zero", 2'd1, 32'd0);
  endtask

  task automatic t_power;
    for (int i = 0; i < 5; i++) push(32'h6000 + i, 32'h7000 + i);
    rd_chk("R8 precondition overflow", 2'd0, 32'h7);
    wr(2'd0, 4'h0);
    rd_chk("R8 ctrl after power-down", 2'd0, 32'h0);
    rd_chk("R8 status after power-down", 2'd1, 32'd0);
    wr(2'd0, 4'h2);
    push(32'h8000, 32'h8100);
    rd_chk("R2 enable without power", 2'd1, 32'd0);
    wr(2'd0, 4'h3);
    rd_chk("R8 data empty after repower", 2'd2, 32'h0);
    rd_chk("R8 status after repower", 2'd1, 32'd0);
  endtask

  task automatic t_regmap;
    wr(2'd0, 4'hB);
    rd_chk("R10 loop-compress bit readback", 2'd0, 32'hB);
    rd_chk("R10 unmapped offset", 2'd3, 32'h0);
    wr(2'd0, 4'h1);
    rd_chk("R10 ctrl rewrite", 2'd0, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_overflow();
    t_simul();
    t_power();
    t_regmap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule